// File: doc/BRIEF.md
# Half-Flash Converter Host Sequencer

This block sits on the host side of an 8-bit half-flash analog-to-digital converter. It drives the converter's active-low chip-select, write and read strobes, and it watches the converter's active-low completion flag and its ready line. It latches the converted byte and hands it to the surrounding logic together with a one-cycle valid pulse. All timing is counted in clock cycles and set by parameters, so one instance can be retargeted to another clock rate.

A conversion starts with a one-cycle start request. The configuration inputs are sampled at that moment. In write-first mode the sequencer holds write low for a fixed time and then releases it. It then reads either after a fixed spacing (fast read) or once the completion flag has been seen (flag wait). In read-only mode it pulls read low and keeps it low until the converter reports completion and is no longer busy. A watchdog abandons a conversion whose completion flag never arrives.

Top module: `hfadc_host_ctrl`

## Requirements
- R1: While reset is applied and after it is released, cs_n_o, wr_n_o and rd_n_o are high (1), and busy_o, result_vld_o and timeout_o are low (0).
- R2: In write-first mode (cfg_wr_first_i=1 at start), wr_n_o is low for exactly WR_LOW_CYC cycles, cs_n_o is low during that time and rd_n_o stays high.
- R3: In write-first mode with fast read (cfg_fast_i=1 at start), rd_n_o falls exactly WR2RD_CYC cycles after wr_n_o rises, whatever the completion flag does.
- R4: In write-first mode with flag wait (cfg_fast_i=0), rd_n_o falls only after the synchronised completion flag (int_n_i) has been seen low, and never earlier than the converter asserts it.
- R5: In read-only mode (cfg_wr_first_i=0), wr_n_o never pulses, and rd_n_o stays low until the synchronised completion flag is low.
- R6: While the synchronised ready input (rdy_i) is low, the converter counts as busy: rd_n_o stays low and no result is captured.
- R7: The data byte is captured on the clock edge after the synchronised flag is seen low with read held low for at least RD_MIN_CYC cycles. result_vld_o is then high for exactly one cycle with result_o equal to the converter's byte, and all strobes are high in that cycle.
- R8: If a conversion has not completed TIMEOUT_CYC cycles after its start was accepted, timeout_o pulses for one cycle, all strobes return high, busy_o drops and no result is produced.
- R9: busy_o is high from the cycle after an accepted start until the conversion ends, and a start request while busy_o is high starts no second conversion.
- R10: A start request in the cycle in which result_vld_o is high is accepted, and a new conversion begins.
- R11: The mode inputs are sampled only when a start is accepted; changing them during a conversion has no effect on its strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, one cycle |
| cfg_wr_first_i | input | 1 | 1: write-first mode, 0: read-only mode |
| cfg_fast_i | input | 1 | Write-first only: 1 fast fixed-delay read, 0 wait for flag |
| cs_n_o | output | 1 | Converter chip-select, active low |
| wr_n_o | output | 1 | Converter write strobe, active low |
| rd_n_o | output | 1 | Converter read strobe, active low |
| int_n_i | input | 1 | Converter completion flag, active low, asynchronous |
| rdy_i | input | 1 | Converter ready, low while busy, asynchronous |
| adc_data_i | input | DATA_W | Converter data bus |
| result_o | output | DATA_W | Captured conversion result |
| result_vld_o | output | 1 | One-cycle pulse marking result_o as new |
| busy_o | output | 1 | Conversion in progress |
| timeout_o | output | 1 | One-cycle pulse: conversion abandoned by the watchdog |

## Verification
Two things can fall in the same cycle: the end of one conversion (result_vld_o high, busy_o just dropped) and the start request for the next one. The bench waits for the valid pulse and drives start_i in that same cycle. It expects the scoreboard to pop the old byte and to see busy_o high one cycle later. It also expects a fresh write pulse to bring in the second byte. A further collision puts a start request on top of a running conversion, and the converter model's write-pulse count must show that the request was dropped.

// File: rtl/hfadc_pkg.sv
`timescale 1ns/1ps
package hfadc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WR_LOW = 2'd1,
      ST_WR_GAP = 2'd2,
      ST_RD_ACT = 2'd3
   } hfadc_state_e;

   typedef struct packed {
      logic wr_first;
      logic fast;
   } hfadc_cfg_t;

   typedef struct packed {
      logic cs_n;
      logic wr_n;
      logic rd_n;
   } hfadc_strobe_t;

   function automatic hfadc_strobe_t strobes_for(hfadc_state_e s);
      hfadc_strobe_t r;
      unique case (s)
         ST_WR_LOW: r = '{cs_n: 1'b0, wr_n: 1'b0, rd_n: 1'b1};
         ST_WR_GAP: r = '{cs_n: 1'b0, wr_n: 1'b1, rd_n: 1'b1};
         ST_RD_ACT: r = '{cs_n: 1'b0, wr_n: 1'b1, rd_n: 1'b0};
         default:   r = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/hfadc_sync.sv
`timescale 1ns/1ps
module hfadc_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("hfadc_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hfadc_counter.sv
`timescale 1ns/1ps
module hfadc_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)               cnt_o <= '0;
      else if (clr_i)           cnt_o <= '0;
      else if (cnt_o != '1)     cnt_o <= cnt_o + 1'b1;
endmodule

// File: rtl/hfadc_seq.sv
`timescale 1ns/1ps
module hfadc_seq
   import hfadc_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int WD_W        = 10,
   parameter int WR_LOW_CYC  = 120,
   parameter int WR2RD_CYC   = 120,
   parameter int RD_MIN_CYC  = 2,
   parameter int TIMEOUT_CYC = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  hfadc_cfg_t       cfg_live_i,
   input  logic             int_low_i,
   input  logic             rdy_i,
   input  logic [CNT_W-1:0] phase_cnt_i,
   input  logic [WD_W-1:0]  wd_cnt_i,
   output logic             phase_clr_o,
   output logic             wd_clr_o,
   output hfadc_state_e     state_o,
   output hfadc_cfg_t       cfg_o,
   output hfadc_strobe_t    strobe_o,
   output logic             cap_o,
   output logic             tmo_o
);
   localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_LOW_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(WR2RD_CYC - 1);
   localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_MIN_CYC - 1);
   localparam logic [WD_W-1:0]  WD_LAST  = WD_W'(TIMEOUT_CYC - 1);

   hfadc_state_e state_q, nxt;
   hfadc_cfg_t   cfg_q;
   logic         accept;

   assign accept = (state_q == ST_IDLE) && start_i;

   always_comb begin
      nxt   = state_q;
      cap_o = 1'b0;
      tmo_o = 1'b0;
      unique case (state_q)
         ST_IDLE:   if (start_i)
                       nxt = cfg_live_i.wr_first ? ST_WR_LOW : ST_RD_ACT;
         ST_WR_LOW: if (phase_cnt_i == WR_LAST) nxt = ST_WR_GAP;
         ST_WR_GAP: if (cfg_q.fast ? (phase_cnt_i == GAP_LAST) : int_low_i)
                       nxt = ST_RD_ACT;
         ST_RD_ACT: if ((phase_cnt_i >= RD_LAST) && int_low_i && rdy_i) begin
                       cap_o = 1'b1;
                       nxt   = ST_IDLE;
                    end
         default:   nxt = ST_IDLE;
      endcase
      if ((state_q != ST_IDLE) && !cap_o && (wd_cnt_i == WD_LAST)) begin
         tmo_o = 1'b1;
         nxt   = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         strobe_o <= strobes_for(ST_IDLE);
         cfg_q    <= '0;
      end else begin
         state_q  <= nxt;
         strobe_o <= strobes_for(nxt);
         if (accept) cfg_q <= cfg_live_i;
      end

   assign phase_clr_o = (nxt != state_q);
   assign wd_clr_o    = (state_q == ST_IDLE);
   assign state_o     = state_q;
   assign cfg_o       = cfg_q;
endmodule

// File: rtl/hfadc_host_ctrl.sv
`timescale 1ns/1ps
module hfadc_host_ctrl
   import hfadc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int WR_LOW_CYC  = 120,
   parameter int WR2RD_CYC   = 120,
   parameter int RD_MIN_CYC  = 2,
   parameter int TIMEOUT_CYC = 1000,
   parameter int SYNC_STAGES = 2,
   parameter bit FAST_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cfg_wr_first_i,
   input  logic              cfg_fast_i,
   output logic              cs_n_o,
   output logic              wr_n_o,
   output logic              rd_n_o,
   input  logic              int_n_i,
   input  logic              rdy_i,
   input  logic [DATA_W-1:0] adc_data_i,
   output logic [DATA_W-1:0] result_o,
   output logic              result_vld_o,
   output logic              busy_o,
   output logic              timeout_o
);
   localparam int PH_MAX = (WR_LOW_CYC > WR2RD_CYC) ?
                           ((WR_LOW_CYC > RD_MIN_CYC) ? WR_LOW_CYC : RD_MIN_CYC) :
                           ((WR2RD_CYC > RD_MIN_CYC) ? WR2RD_CYC : RD_MIN_CYC);
   localparam int CNT_W  = $clog2(PH_MAX + 1);
   localparam int WD_W   = $clog2(TIMEOUT_CYC + 1);

   generate
      if (DATA_W < 1)
         $error("DATA_W must be positive");
      if (WR_LOW_CYC <= SYNC_STAGES || WR2RD_CYC < 1 || RD_MIN_CYC < 1)
         $error("phase lengths too short for the synchroniser depth");
      if (TIMEOUT_CYC <= WR_LOW_CYC + WR2RD_CYC)
         $error("TIMEOUT_CYC must exceed the write phases");
   endgenerate

   logic          int_s, rdy_s;
   logic          fast_eff;
   hfadc_cfg_t    cfg_live, cfg_q;
   hfadc_state_e  state;
   hfadc_strobe_t strobe;
   logic [CNT_W-1:0] phase_cnt;
   logic [WD_W-1:0]  wd_cnt;
   logic          phase_clr, wd_clr, cap, tmo;
   logic          cfg_wr_first_q, cfg_fast_q;

   hfadc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({int_n_i, rdy_i}), .q_o({int_s, rdy_s}));

   generate
      if (FAST_EN) begin : g_fast
         assign fast_eff = cfg_fast_i;
      end else begin : g_nofast
         assign fast_eff = 1'b0;
      end
   endgenerate

   assign cfg_live = '{wr_first: cfg_wr_first_i, fast: fast_eff};

   hfadc_counter #(.W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .clr_i(phase_clr), .cnt_o(phase_cnt));

   hfadc_counter #(.W(WD_W)) u_wdog (
      .clk(clk), .rst_n(rst_n), .clr_i(wd_clr), .cnt_o(wd_cnt));

   hfadc_seq #(
      .CNT_W(CNT_W), .WD_W(WD_W), .WR_LOW_CYC(WR_LOW_CYC), .WR2RD_CYC(WR2RD_CYC),
      .RD_MIN_CYC(RD_MIN_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_live_i(cfg_live),
      .int_low_i(!int_s), .rdy_i(rdy_s), .phase_cnt_i(phase_cnt), .wd_cnt_i(wd_cnt),
      .phase_clr_o(phase_clr), .wd_clr_o(wd_clr), .state_o(state), .cfg_o(cfg_q),
      .strobe_o(strobe), .cap_o(cap), .tmo_o(tmo));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         result_o     <= '0;
         result_vld_o <= 1'b0;
         timeout_o    <= 1'b0;
      end else begin
         result_vld_o <= cap;
         timeout_o    <= tmo;
         if (cap) result_o <= adc_data_i;
      end

   assign cfg_wr_first_q = cfg_q.wr_first;
   assign cfg_fast_q     = cfg_q.fast;
   assign busy_o = (state != ST_IDLE);
   assign cs_n_o = strobe.cs_n;
   assign wr_n_o = strobe.wr_n;
   assign rd_n_o = strobe.rd_n;
endmodule

// File: rtl/hfadc_host_chk.sv
`timescale 1ns/1ps
module hfadc_host_chk #(
   parameter int WR2RD_CYC = 120
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic cs_n_o,
   input logic wr_n_o,
   input logic rd_n_o,
   input logic int_s,
   input logic rdy_s,
   input logic result_vld_o,
   input logic busy_o,
   input logic timeout_o,
   input logic cfg_wr_first_q,
   input logic cfg_fast_q
);
   logic [15:0] since_wr;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)              since_wr <= '0;
      else if (!wr_n_o)        since_wr <= '0;
      else if (since_wr != '1) since_wr <= since_wr + 1'b1;

   // R2: no read while write strobe is low, and chip-select accompanies it
   p_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_o |-> (rd_n_o && !cs_n_o));

   // R3: fast read spacing measured from write rising
   p_fast_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n_o) && cfg_wr_first_q && cfg_fast_q) |-> (since_wr == 16'(WR2RD_CYC)));

   // R4: flag-wait read begins only after the flag was seen
   p_flag_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n_o) && cfg_wr_first_q && !cfg_fast_q) |-> !$past(int_s));

   // R5: read-only mode never pulses write
   p_no_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !cfg_wr_first_q) |-> wr_n_o);

   // R6: capture only when ready and flag were seen
   p_rdy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld_o |-> ($past(rdy_s) && !$past(int_s)));

   // R7: valid is a single-cycle pulse with strobes released
   p_vld_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld_o |-> (cs_n_o && rd_n_o && wr_n_o) ##1 !result_vld_o);

   // R8: watchdog exit releases everything
   p_tmo_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (cs_n_o && rd_n_o && !busy_o && !result_vld_o));

   // R9: busy only rises from an accepted request
   p_busy_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));
endmodule

bind hfadc_host_ctrl hfadc_host_chk #(.WR2RD_CYC(WR2RD_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .cs_n_o(cs_n_o), .wr_n_o(wr_n_o),
   .rd_n_o(rd_n_o), .int_s(int_s), .rdy_s(rdy_s), .result_vld_o(result_vld_o),
   .busy_o(busy_o), .timeout_o(timeout_o), .cfg_wr_first_q(cfg_wr_first_q),
   .cfg_fast_q(cfg_fast_q));

// File: tb/sim_hfadc_host_ctrl.sv
`timescale 1ns/1ps
module sim_hfadc_host_ctrl;
   localparam int WR_LOW  = 120;
   localparam int WR2RD   = 120;
   localparam int TMO     = 1000;
   localparam int INT_DLY = 160;
   localparam int RO_DLY  = 320;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, cfg_wr = 1'b0, cfg_fast = 1'b0;
   logic cs_n, wr_n, rd_n, vld, busy, tmo;
   logic [7:0] result;
   logic m_int_n = 1'b1, m_rdy = 1'b1;
   logic [7:0] m_data = 8'h00;

   int errors = 0, checks = 0;
   int cyc = 0;
   logic [7:0] expq [$];

   // converter model knobs and measurements
   logic [7:0] cur_sample = 8'h00;
   bit mute = 0;
   int rdy_extra = 0;
   int wr_falls = 0, wr_width = 0, rd_gap = 0, rd_width = 0, tmo_cnt = 0, tmo_cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   hfadc_host_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_wr_first_i(cfg_wr),
      .cfg_fast_i(cfg_fast), .cs_n_o(cs_n), .wr_n_o(wr_n), .rd_n_o(rd_n),
      .int_n_i(m_int_n), .rdy_i(m_rdy), .adc_data_i(m_data), .result_o(result),
      .result_vld_o(vld), .busy_o(busy), .timeout_o(tmo));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // converter model
   logic p_wr = 1'b1, p_rd = 1'b1;
   logic [7:0] m_sample = 8'h00;
   bit armed = 0, conv = 0;
   int wr_lo = 0, gap = 0, tw = 0, rc = 0, rd_lo = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_int_n <= 1'b1; m_rdy <= 1'b1; m_data <= 8'h00;
         armed = 0; conv = 0; p_wr = 1'b1; p_rd = 1'b1;
      end else begin
         if (p_wr && !wr_n) begin
            wr_falls++; m_sample = cur_sample; m_int_n <= 1'b1; wr_lo = 0; armed = 0;
         end
         if (!wr_n) wr_lo++;
         if (!p_wr && wr_n) begin wr_width = wr_lo; armed = 1; gap = 0; tw = 0; end
         if (p_rd && !rd_n) begin
            if (armed) begin
               rd_gap = gap + (rd_n ? 1 : 0); armed = 0;
               m_int_n <= 1'b0; m_data <= m_sample;
            end else begin
               m_sample = cur_sample; m_rdy <= 1'b0; conv = 1; rc = 0;
            end
            rd_lo = 0;
         end
         if (armed && rd_n) begin
            gap++; tw++;
            if (tw == INT_DLY && !mute) begin m_int_n <= 1'b0; m_data <= m_sample; end
         end
         if (!rd_n) rd_lo++;
         if (conv) begin
            rc++;
            if (rc == RO_DLY) begin m_int_n <= 1'b0; m_data <= m_sample; end
            if (rc >= RO_DLY + rdy_extra) begin m_rdy <= 1'b1; conv = 0; end
         end
         if (!p_rd && rd_n) begin
            rd_width = rd_lo; m_int_n <= 1'b1; m_data <= 8'h00; m_rdy <= 1'b1; conv = 0;
         end
         p_wr = wr_n; p_rd = rd_n;
      end
   end

   // scoreboard monitor (R7)
   logic p_vld = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (vld) begin
            if (expq.size() == 0) chk(0, "R7 unexpected result", result, -1);
            else begin
               automatic logic [7:0] e = expq.pop_front();
               chk(result == e, "R7 result byte", result, e);
            end
         end
         if (p_vld) chk(!vld, "R7 valid one cycle", vld, 0);
         if (tmo) begin tmo_cnt++; tmo_cyc = cyc; end
         p_vld = vld;
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   task automatic convert(input bit wr_first, input bit fast, input logic [7:0] smp,
                          input bit m, input int extra);
      cfg_wr = wr_first; cfg_fast = fast; cur_sample = smp; mute = m; rdy_extra = extra;
      if (!m) expq.push_back(smp);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   int base, t0;
   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n && wr_n && rd_n, "R1 strobes in reset", {cs_n, wr_n, rd_n}, 7);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(cs_n && wr_n && rd_n, "R1 strobes after reset", {cs_n, wr_n, rd_n}, 7);
      chk(!busy && !vld && !tmo, "R1 status after reset", {busy, vld, tmo}, 0);

      // flag-wait write-first
      convert(1, 0, 8'hA5, 0, 0);
      chk(busy, "R9 busy after start", busy, 1);
      wait_idle();
      chk(wr_width == WR_LOW, "R2 write width", wr_width, WR_LOW);
      chk(rd_gap >= INT_DLY, "R4 read after flag", rd_gap, INT_DLY);

      // fast read
      convert(1, 1, 8'h3C, 0, 0);
      wait_idle();
      chk(wr_width == WR_LOW, "R2 write width fast", wr_width, WR_LOW);
      chk(rd_gap == WR2RD, "R3 fast spacing", rd_gap, WR2RD);
      convert(1, 1, 8'hFF, 0, 0);
      wait_idle();
      chk(rd_gap == WR2RD, "R3 fast spacing again", rd_gap, WR2RD);

      // read-only, with R11 config change mid conversion
      base = wr_falls;
      convert(0, 0, 8'h5A, 0, 0);
      repeat (10) @(negedge clk);
      cfg_wr = 1'b1; cfg_fast = 1'b1;
      wait_idle();
      chk(wr_falls == base, "R5 R11 no write in read-only", wr_falls - base, 0);
      chk(rd_width >= RO_DLY, "R5 read held to completion", rd_width, RO_DLY);

      // ready held low past the flag
      convert(0, 0, 8'h00, 0, 60);
      wait_idle();
      chk(rd_width >= RO_DLY + 60, "R6 read held while busy", rd_width, RO_DLY + 60);

      // start while busy ignored
      base = wr_falls;
      convert(1, 0, 8'h81, 0, 0);
      repeat (50) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (150) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_idle();
      repeat (20) @(negedge clk);
      chk(wr_falls == base + 1, "R9 start ignored while busy", wr_falls - base, 1);
      chk(!busy && expq.size() == 0, "R9 no second conversion", expq.size(), 0);

      // start in the valid cycle
      base = wr_falls;
      convert(1, 0, 8'h42, 0, 0);
      @(negedge clk);
      while (!vld) @(negedge clk);
      cur_sample = 8'hC3; expq.push_back(8'hC3); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy, "R10 start in valid cycle accepted", busy, 1);
      wait_idle();
      chk(wr_falls == base + 2, "R10 second write pulse", wr_falls - base, 2);

      // watchdog
      base = tmo_cnt;
      cfg_wr = 1'b1; cfg_fast = 1'b0; mute = 1;
      @(negedge clk); start = 1'b1; t0 = cyc;
      @(negedge clk); start = 1'b0;
      wait_idle();
      chk(tmo_cnt == base + 1, "R8 timeout pulse", tmo_cnt - base, 1);
      chk(tmo_cyc - t0 == TMO + 1, "R8 timeout latency", tmo_cyc - t0, TMO + 1);
      chk(cs_n && rd_n && !busy, "R8 strobes released", {cs_n, rd_n, busy}, 6);
      mute = 0;

      // recovery after timeout
      convert(1, 0, 8'h96, 0, 0);
      wait_idle();
      chk(expq.size() == 0, "R7 all results delivered", expq.size(), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule